// File: doc/BRIEF.md
# I2C Master Byte Receiver

This block is the receiving side of an I2C bus master. In receive mode, software starts the first frame with a dummy read of the data register. The block then generates SCL from a programmable half-period divider of the system clock. It samples SDA on each SCL rising edge, most significant bit first. On the ninth clock it drives an acknowledge level chosen by software. SDA and SCL are open-drain lines, so the block only drives output enables that pull them low.

Each completed byte appears in a data register, and a receive-full flag is raised at the ninth rising edge. Reception continues frame after frame on its own. If software has not read the previous byte by the time the eighth SCL cycle of the next frame falls, SCL is held low until the read happens. A read made with the "last byte" control set marks the next frame to complete as the final one. After that frame the block gives one extra SCL pulse with SDA held low, releases SDA while SCL is high to form a stop condition, raises a stop flag and returns to idle.

Top module: `i2c_mrx_engine`

## Requirements
- R1: A read (`rd_en` high for one cycle) starts a frame only when the block is idle, `rx_mode` is 1 and `rx_full` is 0. `busy` is 1 on the next cycle. With `rx_mode` at 0 a read leaves `busy` at 0 and SCL released.
- R2: Every SCL high period inside a transfer lasts exactly `div_cfg`+1 clock cycles.
- R3: Data bits are sampled MSB first at SCL rising edges. At the ninth rising edge the byte appears on `rd_data` and `rx_full` becomes 1.
- R4: On the ninth SCL clock of every frame, SDA is pulled low (`sda_oe`=1) when `ack_level` is 0 and released when it is 1.
- R5: A read returns the current byte on `rd_data` during the access, and `rx_full` is 0 on the following cycle.
- R6: While `rx_full` is 1, SCL is held low after the eighth falling edge of the next frame until a read occurs. Reception then resumes.
- R7: A read made with `last_rx`=1 marks the next frame to reach its ninth rising edge as final. That frame produces ten SCL rising edges. SDA then rises while SCL is high (a stop), after which `stop_done` is 1, `busy` is 0 and both lines are released.
- R8: After a stop, a read while `rx_full` is 1 clears the flag without starting a frame.
- R9: After reset, `scl_oe`, `sda_oe`, `busy`, `rx_full` and `stop_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | DIV_W | SCL half period minus one, in clock cycles |
| rx_mode | input | 1 | Master receive direction selected |
| ack_level | input | 1 | Level sent on the ninth clock (0 = acknowledge) |
| last_rx | input | 1 | Marks the next completing frame as final when sampled with a read |
| rd_en | input | 1 | Data register read strobe |
| rd_data | output | BITS | Last received byte |
| rx_full | output | 1 | Received byte waiting to be read |
| stop_done | output | 1 | Stop condition completed |
| busy | output | 1 | Transfer in progress |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
A slave model serves byte streams in three configurations. One is a four-byte run with prompt reads, acknowledge and a slow divider, using mixed, all-zero and all-one bytes that separate bit-order errors from stuck sampling. Another is a two-byte run with a delayed first read and not-acknowledge, which shows whether the clock stretch starts after exactly seventeen rising edges. The last is a single-byte run started with the last-byte control at the fastest divider, which checks the extra tenth pulse and the stop edge. Each run also measures high-phase lengths and compares the acknowledge level seen on the line.

// File: rtl/i2c_mrx_pkg.sv
package i2c_mrx_pkg;
  typedef enum logic [1:0] {
    MRX_IDLE = 2'd0,
    MRX_LOW  = 2'd1,
    MRX_HIGH = 2'd2,
    MRX_STOP = 2'd3
  } mrx_state_e;
endpackage

// File: rtl/i2c_mrx_halfper.sv
module i2c_mrx_halfper #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign tick   = run && !hold && (cnt_q == '0);
  assign cnt_en = 1'b1;

  // Reload while idle or stalled, so each phase after a stall is full length.
  always_comb begin
    cnt_d = cnt_q;
    if (!run || hold || tick) cnt_d = div;
    else                      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_mrx_shifter.sv
module i2c_mrx_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample,
  input  logic            sda_in,
  input  logic            load,
  input  logic            rd_en,
  output logic [BITS-1:0] rd_data,
  output logic            full
);
  logic [BITS-1:0] sh_q, sh_d, dat_q, dat_d;
  logic            full_q, full_d;

  always_comb begin
    sh_d   = sample ? {sh_q[BITS-2:0], sda_in} : sh_q;
    dat_d  = load ? sh_q : dat_q;
    full_d = full_q;
    if (load)       full_d = 1'b1;
    else if (rd_en) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      dat_q  <= '0;
      full_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      dat_q  <= dat_d;
      full_q <= full_d;
    end
  end

  assign rd_data = dat_q;
  assign full    = full_q;
endmodule

// File: rtl/i2c_mrx_seq.sv
module i2c_mrx_seq
  import i2c_mrx_pkg::*;
#(
  parameter int BITS  = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rd_en,
  input  logic             rx_mode,
  input  logic             last_rx,
  input  logic             full,
  input  logic             ack_level,
  output mrx_state_e       st,
  output logic [IDX_W-1:0] idx,
  output logic             sample,
  output logic             load,
  output logic             hold,
  output logic             run,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             stop_done
);
  localparam logic [IDX_W-1:0] IDX_ACK  = IDX_W'(BITS);
  localparam logic [IDX_W-1:0] IDX_XTRA = IDX_W'(BITS + 1);

  mrx_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             arm_q, arm_d, fin_q, fin_d, stp_q, stp_d;
  logic             arm_now;

  assign arm_now = arm_q || (rd_en && last_rx);
  assign hold    = (st_q == MRX_LOW) && (idx_q == IDX_ACK) && full;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    arm_d  = arm_now;
    fin_d  = fin_q;
    stp_d  = stp_q;
    sample = 1'b0;
    load   = 1'b0;
    unique case (st_q)
      MRX_IDLE: begin
        arm_d = 1'b0;
        if (rd_en && rx_mode && !full) begin
          st_d  = MRX_LOW;
          idx_d = '0;
          fin_d = 1'b0;
          stp_d = 1'b0;
          arm_d = last_rx;
        end
      end
      MRX_LOW: begin
        if (tick) begin
          st_d = MRX_HIGH;
          if (idx_q < IDX_ACK) sample = 1'b1;
          else if (idx_q == IDX_ACK) begin
            load  = 1'b1;
            fin_d = arm_now;
            arm_d = 1'b0;
          end
        end
      end
      MRX_HIGH: begin
        if (tick) begin
          if (idx_q == IDX_XTRA) st_d = MRX_STOP;
          else begin
            st_d = MRX_LOW;
            if (idx_q == IDX_ACK) idx_d = fin_q ? IDX_XTRA : '0;
            else                  idx_d = idx_q + 1'b1;
          end
        end
      end
      MRX_STOP: begin
        if (tick) begin
          st_d  = MRX_IDLE;
          stp_d = 1'b1;
          fin_d = 1'b0;
        end
      end
      default: st_d = MRX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= MRX_IDLE;
      idx_q <= '0;
      arm_q <= 1'b0;
      fin_q <= 1'b0;
      stp_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      arm_q <= arm_d;
      fin_q <= fin_d;
      stp_q <= stp_d;
    end
  end

  assign st        = st_q;
  assign idx       = idx_q;
  assign run       = (st_q != MRX_IDLE);
  assign scl_oe    = (st_q == MRX_LOW);
  assign sda_oe    = ((st_q == MRX_LOW) || (st_q == MRX_HIGH)) &&
                     (((idx_q == IDX_ACK) && !ack_level) || (idx_q == IDX_XTRA));
  assign stop_done = stp_q;
endmodule

// File: rtl/i2c_mrx_engine.sv
module i2c_mrx_engine
  import i2c_mrx_pkg::*;
#(
  parameter int BITS  = 8,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             rx_mode,
  input  logic             ack_level,
  input  logic             last_rx,
  input  logic             rd_en,
  output logic [BITS-1:0]  rd_data,
  output logic             rx_full,
  output logic             stop_done,
  output logic             busy,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam int IDX_W = $clog2(BITS + 2);

  logic [1:0]       rs_q;
  logic             rst_q_n;
  logic             tick, sample, load, hold, run;
  mrx_state_e       st;
  logic [IDX_W-1:0] idx;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  i2c_mrx_halfper #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_q_n), .run(run), .hold(hold), .div(div_cfg), .tick(tick)
  );

  i2c_mrx_shifter #(.BITS(BITS)) u_shift (
    .clk(clk), .rst_n(rst_q_n), .sample(sample), .sda_in(sda_in), .load(load),
    .rd_en(rd_en), .rd_data(rd_data), .full(rx_full)
  );

  i2c_mrx_seq #(.BITS(BITS), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_q_n), .tick(tick), .rd_en(rd_en), .rx_mode(rx_mode),
    .last_rx(last_rx), .full(rx_full), .ack_level(ack_level), .st(st), .idx(idx),
    .sample(sample), .load(load), .hold(hold), .run(run), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .stop_done(stop_done)
  );

  assign busy = run;
endmodule

// File: rtl/i2c_mrx_checker.sv
module i2c_mrx_checker
  import i2c_mrx_pkg::*;
#(
  parameter int BITS  = 8,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_q_n,
  input mrx_state_e       st,
  input logic [IDX_W-1:0] idx,
  input logic             load,
  input logic             hold,
  input logic             rd_en,
  input logic             rx_full,
  input logic             busy,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             stop_done,
  input logic             ack_level
);
  localparam logic [IDX_W-1:0] IDX_ACK = IDX_W'(BITS);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    !busy |-> (!scl_oe && !sda_oe));

  a_r3_full_on_load: assert property (@(posedge clk) disable iff (!rst_q_n)
    load |=> rx_full);

  a_r4_ack_level: assert property (@(posedge clk) disable iff (!rst_q_n)
    (st == MRX_HIGH && idx == IDX_ACK) |-> (sda_oe == !ack_level));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && rx_full && !load) |=> !rx_full);

  a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_q_n)
    hold |=> scl_oe);

  a_r7_stop_flag: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(busy) |-> stop_done);

  a_r7_stop_edge: assert property (@(posedge clk) disable iff (!rst_q_n)
    (st == MRX_STOP && $past(st) == MRX_HIGH) |-> ($past(sda_oe) && !sda_oe && !scl_oe));

  a_r8_no_start_full: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && rx_full && !busy) |=> !busy);
endmodule

bind i2c_mrx_engine i2c_mrx_checker #(.BITS(BITS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .st(st), .idx(idx), .load(load), .hold(hold),
  .rd_en(rd_en), .rx_full(rx_full), .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .stop_done(stop_done), .ack_level(ack_level)
);

// File: tb/i2c_mrx_engine_test.sv
module i2c_mrx_engine_test;
  logic       clk, rst_n;
  logic [9:0] div_cfg;
  logic       rx_mode, ack_level, last_rx, rd_en;
  logic [7:0] rd_data;
  logic       rx_full, stop_done, busy, scl_oe, sda_oe;
  logic       slave_low;
  wire        scl_line = !scl_oe;
  wire        sda_line = !(sda_oe || slave_low);

  i2c_mrx_engine uut (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .rx_mode(rx_mode),
    .ack_level(ack_level), .last_rx(last_rx), .rd_en(rd_en), .rd_data(rd_data),
    .rx_full(rx_full), .stop_done(stop_done), .busy(busy), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Slave model and scoreboard state
  logic [7:0] slave_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] sl_byte, last_seen;
  bit sl_active = 0, sl_first = 0, sl_have = 0;
  int sl_pos = 0, rises = 0, stops = 0;
  bit exp_ack = 0;

  always @(negedge scl_line) if (sl_active) begin
    if (sl_first || sl_pos == 8) begin
      sl_first = 0;
      sl_pos = 0;
      if (slave_q.size() > 0) begin sl_byte = slave_q.pop_front(); sl_have = 1; end
      else sl_have = 0;
    end else sl_pos++;
    slave_low = sl_have && sl_pos < 8 && !sl_byte[7 - sl_pos];
  end

  always @(posedge scl_line) if (sl_active) begin
    rises++;
    if (sl_pos == 8) check(sda_line == exp_ack, "R4 ack level on ninth clock", sda_line, exp_ack);
  end

  // Monitor: scoreboard pop, stop detection, high-phase length
  bit full_prev = 0, sda_prev = 1, scl_prev = 1, hvalid = 0;
  int hrun = 0, r2_seen = 0, r2_bad = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_full && !full_prev) begin
        if (exp_q.size() == 0) check(0, "R3 unexpected byte", rd_data, -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rd_data == e, "R3 received byte", rd_data, e);
          last_seen = e;
        end
      end
      if (sl_active && scl_prev && scl_line && !sda_prev && sda_line) stops++;
      if (!busy) begin hrun = 0; hvalid = 0; end
      else if (scl_line) hrun++;
      else begin
        if (hvalid && hrun > 0) begin
          r2_seen++;
          if (hrun != int'(div_cfg) + 1) r2_bad++;
        end
        hrun = 0;
        hvalid = 1;
      end
    end
    full_prev = rx_full;
    sda_prev = sda_line;
    scl_prev = scl_line;
  end

  task automatic rd_pulse(input bit last, input bit chk);
    @(negedge clk);
    rd_en = 1; last_rx = last;
    if (chk) check(rd_data == last_seen, "R5 read returns byte", rd_data, last_seen);
    @(negedge clk);
    rd_en = 0; last_rx = 0;
    if (chk) check(rx_full == 0, "R5 flag cleared by read", rx_full, 0);
  endtask

  task automatic run_xfer(input logic [7:0] d0, d1, d2, d3, input int n,
                          input int div, input bit ack, input int stall_delay);
    logic [7:0] d[4];
    int r0, s0;
    d = '{d0, d1, d2, d3};
    div_cfg = 10'(div);
    ack_level = ack;
    exp_ack = ack;
    for (int i = 0; i < n; i++) begin slave_q.push_back(d[i]); exp_q.push_back(d[i]); end
    r2_seen = 0; r2_bad = 0;
    r0 = rises; s0 = stops;
    sl_first = 1; sl_active = 1;
    rx_mode = 1;
    rd_pulse(n == 1, 0);
    check(busy == 1, "R1 dummy read starts frame", busy, 1);
    for (int i = 0; i < n - 1; i++) begin
      while (!rx_full) @(negedge clk);
      if (i == 0 && stall_delay > 0) begin
        repeat (stall_delay) @(negedge clk);
        check(scl_oe == 1, "R6 SCL held low while full", scl_oe, 1);
        check(rises - r0 == 17, "R6 stall after eighth clock", rises - r0, 17);
      end
      rd_pulse(i == n - 2, 1);
    end
    while (!stop_done) @(negedge clk);
    @(negedge clk);
    check(busy == 0, "R7 idle after stop", busy, 0);
    check(rises - r0 == 9 * n + 1, "R7 rising edges incl extra", rises - r0, 9 * n + 1);
    check(stops - s0 == 1, "R7 stop condition seen", stops - s0, 1);
    check(!scl_oe && !sda_oe, "R7 lines released", {scl_oe, sda_oe}, 0);
    check(rx_full == 1, "R3 final byte flagged", rx_full, 1);
    check(exp_q.size() == 0, "R3 all bytes delivered", exp_q.size(), 0);
    check(r2_bad == 0 && r2_seen > 0, "R2 high period length", r2_bad, 0);
    rd_pulse(0, 1);
    repeat (30) @(negedge clk);
    check(busy == 0, "R8 read after stop starts nothing", busy, 0);
    check(rx_full == 0, "R8 flag cleared after stop", rx_full, 0);
    sl_active = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst_n = 0; div_cfg = 10'd3; rx_mode = 0; ack_level = 0; last_rx = 0; rd_en = 0;
    slave_low = 0; last_seen = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check({scl_oe, sda_oe, busy, rx_full, stop_done} == 0, "R9 reset state",
          {scl_oe, sda_oe, busy, rx_full, stop_done}, 0);

    // R1: not in receive mode, a read has no effect
    sl_active = 1; sl_first = 1;
    rd_pulse(0, 0);
    repeat (40) @(negedge clk);
    check(busy == 0, "R1 no start outside receive mode", busy, 0);
    check(rises == 0 && scl_oe == 0, "R1 SCL untouched", rises, 0);
    sl_active = 0;

    run_xfer(8'hA5, 8'h3C, 8'h00, 8'hFF, 4, 3, 0, 0);
    run_xfer(8'h5A, 8'h81, 8'h00, 8'h00, 2, 1, 1, 120);
    run_xfer(8'hC3, 8'h00, 8'h00, 8'h00, 1, 0, 0, 0);
    finish_up();
  end
endmodule